// File: doc/BRIEF.md
# Ordered Store Log with Replay

The block keeps a program-ordered record of every retired store (address, value and access size) in a plain circular RAM. Nothing ever searches it by address. Loads get forwarded values from the first-level cache, so the log only has three jobs:
- keep store order for release to the second-level cache;
- throw away the stores of speculative sequences that were rolled back;
- rebuild first-level cache contents by walking its entries and re-issuing them.

A sequence tracker outside the block reads the tail pointer when a sequence opens and remembers its range. It later asks for one of three actions, each as a single-cycle pulse:
- a drain up to a given pointer, when the sequence commits;
- an erase from a given pointer, on rollback;
- a line replay, when a partially invalidated line has been refilled.

Pointers on the ports are one bit wider than the RAM index, and that extra bit is a wrap flag.

A four-state controller orders the work:
- `ST_IDLE` accepts commands with priority erase, then line replay, then drain.
  - A drain request goes to `ST_DRAIN`. If the end pointer already equals the head, it finishes at once.
  - A line replay goes to `ST_LINE_WALK`.
  - An erase loads the tail. If entries survive, it goes to `ST_FULL_WALK`; otherwise it finishes at once.
- `ST_DRAIN` presents the head entry to the second-level port. It pops on every accepted beat and returns to `ST_IDLE` after the pop that makes the head equal to the end pointer.
- `ST_LINE_WALK` and `ST_FULL_WALK` step a walk pointer from head to tail. They return to `ST_IDLE` when it reaches the tail.
- Every return to idle raises `op_done` for one cycle.

Top module: `store_order_log`

## Requirements
- R1: After reset, head and tail pointers are 0, `retire_stall`, `busy`, `op_done`, `l1_valid` and `l2_valid` are all 0.
- R2: A store is taken when `app_valid` is 1 and `retire_stall` is 0 at a rising edge. It is written at the tail slot, and the tail pointer advances by exactly one.
- R3: With DEPTH entries held (tail minus head equals DEPTH), `retire_stall` is 1. A store offered while stalled is not taken, and the tail pointer does not move.
- R4: A drain request with end pointer E delivers the entries from head up to E on the second-level port in append order, one per beat where `l2_valid` and `l2_ready` are both 1. The head advances once per beat, and `op_done` pulses after the last beat.
- R5: A drain request whose end pointer equals the head produces no second-level beat, leaves the head unchanged and pulses `op_done`.
- R6: A line replay request with line tag T walks every entry from head to tail. In append order it issues on the first-level port only the entries whose address bits above LINE_OFF_W equal T. Head and tail stay unchanged, and `retire_stall` is 1 whenever a replay entry is offered.
- R7: An erase request with pointer P sets the tail to P. If P differs from the head, it then issues every surviving entry, head to P, on the first-level port in append order, followed by `op_done`.
- R8: An erase request whose pointer equals the head empties the log, issues no first-level traffic and pulses `op_done`.
- R9: `l1_valid` and `l2_valid` are never 1 together. A command pulse that arrives while `busy` is 1 has no effect.
- R10: When erase, line replay and drain requests arrive in the same idle cycle, only the erase is performed.
- R11: Stores are taken while a drain is running, as soon as a pop leaves a free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_valid | input | 1 | Retiring store offered |
| app_addr | input | ADDR_W | Store address |
| app_data | input | DATA_W | Store value |
| app_size | input | SIZE_W | Access size code |
| retire_stall | output | 1 | Hold retirement: log full, replay running, or erase arriving |
| head_ptr | output | $clog2(DEPTH)+1 | Oldest entry pointer with wrap bit |
| tail_ptr | output | $clog2(DEPTH)+1 | Next free slot pointer with wrap bit |
| drain_req | input | 1 | Pulse: release entries to second level |
| drain_ptr | input | $clog2(DEPTH)+1 | Pointer one past the last entry to release |
| erase_req | input | 1 | Pulse: discard entries from erase_ptr onward |
| erase_ptr | input | $clog2(DEPTH)+1 | First discarded entry, becomes the new tail |
| inval_req | input | 1 | Pulse: replay stores of one line |
| inval_line | input | ADDR_W-LINE_OFF_W | Line tag to replay |
| busy | output | 1 | Controller not idle |
| op_done | output | 1 | One-cycle completion pulse |
| l2_valid | output | 1 | Drain beat valid |
| l2_ready | input | 1 | Second level accepts beat |
| l2_addr | output | ADDR_W | Drain address |
| l2_data | output | DATA_W | Drain value |
| l2_size | output | SIZE_W | Drain size |
| l1_valid | output | 1 | Replay beat valid |
| l1_ready | input | 1 | First level accepts beat |
| l1_addr | output | ADDR_W | Replay address |
| l1_data | output | DATA_W | Replay value |
| l1_size | output | SIZE_W | Replay size |

## Verification
The bench attacks the following corner cases, each paired with the failure it would catch:
- **Wrap-around while draining.** A store is appended into the slot that the same drain has just freed. A pointer compare without the wrap bit would report the log empty or full at the wrong time and would lose or duplicate stores.
- **Line replay filtering.** Matching stores sit among stores to other lines. A wrong tag slice or a filter that is ignored would replay foreign stores into the cache.
- **Erase back to the head.** This covers the eldest sequence being discarded. An erase that does not check for it would replay stale entries.
- **Simultaneous commands.** Erase, replay and drain pulses arrive in the same cycle. A wrong priority order would show up as traffic on the second-level port.
- **Commands while busy.** A drain pulse arrives during a replay. A controller that takes it would emit second-level beats and move the head.

// File: rtl/sol_pkg.sv
`timescale 1ns/1ps
package sol_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_LINE_WALK,
        ST_FULL_WALK
    } sol_state_e;

endpackage

// File: rtl/sol_store_ram.sv
`timescale 1ns/1ps
// Entry storage: one write port for appends, one read port shared by the
// drain path and the replay walker (never active together).
module sol_store_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 66
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [WIDTH-1:0]         rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/sol_ptr_ctrl.sv
`timescale 1ns/1ps
// Head and tail pointers with a wrap bit; occupancy and full/empty flags.
module sol_ptr_ctrl #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    input  logic                     tail_load,
    input  logic [$clog2(DEPTH):0]   tail_val,
    output logic [$clog2(DEPTH):0]   head_ptr,
    output logic [$clog2(DEPTH):0]   tail_ptr,
    output logic                     full,
    output logic                     empty
);

    localparam int PTR_W = $clog2(DEPTH) + 1;

    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic [PTR_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (pop) begin
                head_q <= head_q + 1'b1;
            end
            if (tail_load) begin
                tail_q <= tail_val;
            end else if (push) begin
                tail_q <= tail_q + 1'b1;
            end
        end
    end

    assign occ      = tail_q - head_q;
    assign full     = (occ == PTR_W'(DEPTH));
    assign empty    = (occ == '0);
    assign head_ptr = head_q;
    assign tail_ptr = tail_q;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !tail_load) |=> (tail_q == PTR_W'($past(tail_q) + 1'b1)));

    p_push_load_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && tail_load));

endmodule

// File: rtl/sol_line_walker.sv
`timescale 1ns/1ps
// Replay walk pointer plus line-tag comparison for the entry under it.
module sol_line_walker #(
    parameter int DEPTH      = 1024,
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(DEPTH):0]       start_ptr,
    input  logic [ADDR_W-LINE_OFF_W-1:0] tag_in,
    input  logic                         step,
    input  logic [$clog2(DEPTH):0]       tail_ptr,
    input  logic [ADDR_W-1:0]            entry_addr,
    output logic [$clog2(DEPTH):0]       walk_ptr,
    output logic                         at_end,
    output logic                         line_hit
);

    localparam int PTR_W = $clog2(DEPTH) + 1;
    localparam int TAG_W = ADDR_W - LINE_OFF_W;

    logic [PTR_W-1:0] ptr_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            tag_q <= '0;
        end else if (start) begin
            ptr_q <= start_ptr;
            tag_q <= tag_in;
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign walk_ptr = ptr_q;
    assign at_end   = (ptr_q == tail_ptr);
    assign line_hit = (entry_addr[ADDR_W-1:LINE_OFF_W] == tag_q);

    p_walk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && at_end));

endmodule

// File: rtl/store_order_log.sv
`timescale 1ns/1ps
module store_order_log #(
    parameter int DEPTH      = 1024,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int SIZE_W     = 2,
    parameter int LINE_OFF_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         app_valid,
    input  logic [ADDR_W-1:0]            app_addr,
    input  logic [DATA_W-1:0]            app_data,
    input  logic [SIZE_W-1:0]            app_size,
    output logic                         retire_stall,
    output logic [$clog2(DEPTH):0]       head_ptr,
    output logic [$clog2(DEPTH):0]       tail_ptr,
    input  logic                         drain_req,
    input  logic [$clog2(DEPTH):0]       drain_ptr,
    input  logic                         erase_req,
    input  logic [$clog2(DEPTH):0]       erase_ptr,
    input  logic                         inval_req,
    input  logic [ADDR_W-LINE_OFF_W-1:0] inval_line,
    output logic                         busy,
    output logic                         op_done,
    output logic                         l2_valid,
    input  logic                         l2_ready,
    output logic [ADDR_W-1:0]            l2_addr,
    output logic [DATA_W-1:0]            l2_data,
    output logic [SIZE_W-1:0]            l2_size,
    output logic                         l1_valid,
    input  logic                         l1_ready,
    output logic [ADDR_W-1:0]            l1_addr,
    output logic [DATA_W-1:0]            l1_data,
    output logic [SIZE_W-1:0]            l1_size
);

    import sol_pkg::*;

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int PTR_W   = IDX_W + 1;
    localparam int ENTRY_W = ADDR_W + DATA_W + SIZE_W;

    sol_state_e       state_q, state_d;
    logic             done_q, done_d;
    logic [PTR_W-1:0] drain_end_q, drain_end_d;

    logic             push, pop, tail_load, full, empty;
    logic             walk_start, step, at_end, line_hit;
    logic [PTR_W-1:0] walk_ptr;
    logic [IDX_W-1:0] rd_idx;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ADDR_W-1:0]  ent_addr;
    logic [DATA_W-1:0]  ent_data;
    logic [SIZE_W-1:0]  ent_size;
    logic               replaying;

    // ---------------------------------------------------------------- storage
    sol_store_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_ram (
        .clk     (clk),
        .wr_en   (push),
        .wr_idx  (tail_ptr[IDX_W-1:0]),
        .wr_data ({app_addr, app_data, app_size}),
        .rd_idx  (rd_idx),
        .rd_data (rd_entry)
    );

    assign {ent_addr, ent_data, ent_size} = rd_entry;

    sol_ptr_ctrl #(.DEPTH(DEPTH)) i_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .tail_load (tail_load),
        .tail_val  (erase_ptr),
        .head_ptr  (head_ptr),
        .tail_ptr  (tail_ptr),
        .full      (full),
        .empty     (empty)
    );

    sol_line_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) i_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_start),
        .start_ptr  (head_ptr),
        .tag_in     (inval_line),
        .step       (step),
        .tail_ptr   (tail_ptr),
        .entry_addr (ent_addr),
        .walk_ptr   (walk_ptr),
        .at_end     (at_end),
        .line_hit   (line_hit)
    );

    // --------------------------------------------------------- state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            done_q      <= 1'b0;
            drain_end_q <= '0;
        end else begin
            state_q     <= state_d;
            done_q      <= done_d;
            drain_end_q <= drain_end_d;
        end
    end

    // ------------------------------------------------------------ next state
    always_comb begin
        state_d     = state_q;
        done_d      = 1'b0;
        drain_end_d = drain_end_q;
        pop         = 1'b0;
        step        = 1'b0;
        walk_start  = 1'b0;
        tail_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (erase_req) begin
                    tail_load  = 1'b1;
                    walk_start = 1'b1;
                    if (erase_ptr == head_ptr) begin
                        done_d = 1'b1;
                    end else begin
                        state_d = ST_FULL_WALK;
                    end
                end else if (inval_req) begin
                    walk_start = 1'b1;
                    state_d    = ST_LINE_WALK;
                end else if (drain_req) begin
                    if (drain_ptr == head_ptr) begin
                        done_d = 1'b1;
                    end else begin
                        drain_end_d = drain_ptr;
                        state_d     = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (l2_ready) begin
                    pop = 1'b1;
                    if (PTR_W'(head_ptr + 1'b1) == drain_end_q) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end
                end
            end
            ST_LINE_WALK: begin
                if (at_end) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else if (!line_hit || l1_ready) begin
                    step = 1'b1;
                end
            end
            ST_FULL_WALK: begin
                if (at_end) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else if (l1_ready) begin
                    step = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // --------------------------------------------------------------- outputs
    always_comb begin
        l2_valid  = 1'b0;
        l1_valid  = 1'b0;
        replaying = 1'b0;
        rd_idx    = walk_ptr[IDX_W-1:0];
        unique case (state_q)
            ST_IDLE: begin
                rd_idx = head_ptr[IDX_W-1:0];
            end
            ST_DRAIN: begin
                rd_idx   = head_ptr[IDX_W-1:0];
                l2_valid = 1'b1;
            end
            ST_LINE_WALK: begin
                replaying = 1'b1;
                l1_valid  = !at_end && line_hit;
            end
            ST_FULL_WALK: begin
                replaying = 1'b1;
                l1_valid  = !at_end;
            end
            default: ;
        endcase
    end

    assign retire_stall = full || replaying || ((state_q == ST_IDLE) && erase_req);
    assign push         = app_valid && !retire_stall;
    assign busy         = (state_q != ST_IDLE);
    assign op_done      = done_q;
    assign l2_addr      = ent_addr;
    assign l2_data      = ent_data;
    assign l2_size      = ent_size;
    assign l1_addr      = ent_addr;
    assign l1_data      = ent_data;
    assign l1_size      = ent_size;

    // ------------------------------------------------------------ assertions
    p_port_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(l1_valid && l2_valid));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!l1_valid && !l2_valid));

    p_head_hold_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        replaying |=> $stable(head_ptr));

    p_replay_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        l1_valid |-> retire_stall);

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid && !l2_ready) |=> (l2_valid && $stable(l2_addr) && $stable(l2_data)));

    p_drain_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid && l2_ready) |=> (head_ptr == PTR_W'($past(head_ptr) + 1'b1)));

endmodule

// File: tb/test_store_order_log.sv
`timescale 1ns/1ps
module test_store_order_log;

    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int SW    = 2;
    localparam int LO    = 4;
    localparam int PW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic app_valid = 1'b0;
    logic [AW-1:0] app_addr = '0;
    logic [DW-1:0] app_data = '0;
    logic [SW-1:0] app_size = '0;
    logic retire_stall, busy, op_done;
    logic [PW-1:0] head_ptr, tail_ptr;
    logic drain_req = 1'b0, erase_req = 1'b0, inval_req = 1'b0;
    logic [PW-1:0] drain_ptr = '0, erase_ptr = '0;
    logic [AW-LO-1:0] inval_line = '0;
    logic l2_valid, l1_valid;
    logic l2_ready = 1'b1, l1_ready = 1'b1;
    logic [AW-1:0] l2_addr, l1_addr;
    logic [DW-1:0] l2_data, l1_data;
    logic [SW-1:0] l2_size, l1_size;

    store_order_log #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .LINE_OFF_W(LO)) i_store_order_log (
        .clk(clk), .rst_n(rst_n),
        .app_valid(app_valid), .app_addr(app_addr), .app_data(app_data), .app_size(app_size),
        .retire_stall(retire_stall), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
        .drain_req(drain_req), .drain_ptr(drain_ptr),
        .erase_req(erase_req), .erase_ptr(erase_ptr),
        .inval_req(inval_req), .inval_line(inval_line),
        .busy(busy), .op_done(op_done),
        .l2_valid(l2_valid), .l2_ready(l2_ready), .l2_addr(l2_addr), .l2_data(l2_data), .l2_size(l2_size),
        .l1_valid(l1_valid), .l1_ready(l1_ready), .l1_addr(l1_addr), .l1_data(l1_data), .l1_size(l1_size)
    );

    always #2.5 clk = ~clk;

    // Vector: {expected tail after append, addr, data, size}
    localparam logic [37:0] VEC [6] = '{
        {4'd1, 16'h0100, 16'hA001, 2'd2},
        {4'd2, 16'h0204, 16'hB002, 2'd1},
        {4'd3, 16'h0108, 16'hC003, 2'd2},
        {4'd4, 16'h0300, 16'hD004, 2'd0},
        {4'd5, 16'h010C, 16'hE005, 2'd3},
        {4'd6, 16'h0210, 16'hF006, 2'd2}
    };

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [33:0] l1_log [16];
    logic [33:0] l2_log [16];
    int l1_n, l2_n, accepted, nostall;

    task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] gen_item(input int k);
        return {16'h0400 + 16'(4 * k), 16'h5500 + 16'(k), 2'd2};
    endfunction

    task automatic append(input logic [33:0] it);
        @(negedge clk);
        {app_addr, app_data, app_size} = it;
        app_valid = 1'b1;
        @(negedge clk);
        app_valid = 1'b0;
    endtask

    // Runs until op_done; logs port beats; poke_at >= 0 pulses drain_req at that iteration.
    task automatic run_op(input int poke_at);
        bit fin = 0;
        bit acc_last = 0;
        int guard = 0;
        l1_n = 0; l2_n = 0; accepted = 0; nostall = 0;
        while (!fin) begin
            @(negedge clk);
            drain_req = 1'b0; erase_req = 1'b0; inval_req = 1'b0;
            if (guard == poke_at) drain_req = 1'b1;
            if (acc_last) begin app_valid = 1'b0; acc_last = 0; end
            if (l1_valid && l1_ready && l1_n < 16) begin l1_log[l1_n] = {l1_addr, l1_data, l1_size}; l1_n++; end
            if (l2_valid && l2_ready && l2_n < 16) begin l2_log[l2_n] = {l2_addr, l2_data, l2_size}; l2_n++; end
            if (l1_valid && !retire_stall) nostall++;
            if (app_valid && !retire_stall) begin accepted++; acc_last = 1; end
            if (op_done && !drain_req) fin = 1;
            guard++;
            if (guard > 200) begin
                chk(1'b0, "op timeout", 34'(guard), 34'd200);
                fin = 1;
            end
        end
        drain_req = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(head_ptr == 0, "R1 head", 34'(head_ptr), 34'd0);
        chk(tail_ptr == 0, "R1 tail", 34'(tail_ptr), 34'd0);
        chk({retire_stall, busy, op_done, l1_valid, l2_valid} == 0, "R1 flags",
            34'({retire_stall, busy, op_done, l1_valid, l2_valid}), 34'd0);

        // R2: table of appends with expected tail
        for (int i = 0; i < 6; i++) begin
            append(VEC[i][33:0]);
            chk(tail_ptr == VEC[i][37:34], "R2 tail step", 34'(tail_ptr), 34'(VEC[i][37:34]));
        end

        // R6: line replay of tag 0x010, with a drain pulse while busy (R9)
        drain_ptr = 4'd2;
        @(negedge clk); inval_line = 12'h010; inval_req = 1'b1;
        run_op(2);
        chk(l1_n == 3, "R6 replay count", 34'(l1_n), 34'd3);
        chk(l1_log[0] == VEC[0][33:0], "R6 item0", l1_log[0], VEC[0][33:0]);
        chk(l1_log[1] == VEC[2][33:0], "R6 item1", l1_log[1], VEC[2][33:0]);
        chk(l1_log[2] == VEC[4][33:0], "R6 item2", l1_log[2], VEC[4][33:0]);
        chk(nostall == 0, "R6 stall during replay", 34'(nostall), 34'd0);
        chk(head_ptr == 0 && tail_ptr == 6, "R6 pointers kept", 34'({head_ptr, tail_ptr}), 34'h06);
        chk(l2_n == 0, "R9 busy drain ignored", 34'(l2_n), 34'd0);

        // R4: drain sequence 0..1
        @(negedge clk); drain_ptr = 4'd2; drain_req = 1'b1;
        run_op(-1);
        chk(l2_n == 2, "R4 drain count", 34'(l2_n), 34'd2);
        chk(l2_log[0] == VEC[0][33:0], "R4 order0", l2_log[0], VEC[0][33:0]);
        chk(l2_log[1] == VEC[1][33:0], "R4 order1", l2_log[1], VEC[1][33:0]);
        chk(head_ptr == 2, "R4 head", 34'(head_ptr), 34'd2);

        // R5: empty drain range
        @(negedge clk); drain_ptr = 4'd2; drain_req = 1'b1;
        run_op(-1);
        chk(l2_n == 0 && head_ptr == 2, "R5 empty drain", 34'({l2_n[3:0], head_ptr}), 34'h02);

        // R7: erase entries 4..5, replay survivors 2..3
        @(negedge clk); erase_ptr = 4'd4; erase_req = 1'b1;
        run_op(-1);
        chk(tail_ptr == 4, "R7 tail", 34'(tail_ptr), 34'd4);
        chk(l1_n == 2, "R7 replay count", 34'(l1_n), 34'd2);
        chk(l1_log[0] == VEC[2][33:0], "R7 item0", l1_log[0], VEC[2][33:0]);
        chk(l1_log[1] == VEC[3][33:0], "R7 item1", l1_log[1], VEC[3][33:0]);

        // R3: fill to DEPTH, then one refused store
        for (int k = 0; k < 6; k++) append(gen_item(k));
        chk(retire_stall == 1'b1, "R3 stall when full", 34'(retire_stall), 34'd1);
        chk(tail_ptr == 10, "R3 tail at full", 34'(tail_ptr), 34'd10);
        append(gen_item(9));
        chk(tail_ptr == 10, "R3 refused store", 34'(tail_ptr), 34'd10);

        // R11: drain 4 entries with a store waiting for space (wraps into slot 2)
        @(negedge clk);
        drain_ptr = 4'd6; drain_req = 1'b1;
        {app_addr, app_data, app_size} = gen_item(7);
        app_valid = 1'b1;
        run_op(-1);
        app_valid = 1'b0;
        chk(accepted == 1, "R11 store during drain", 34'(accepted), 34'd1);
        chk(tail_ptr == 11 && head_ptr == 6, "R11 pointers", 34'({tail_ptr, head_ptr}), 34'hB6);
        chk(l2_n == 4, "R4 wrap drain count", 34'(l2_n), 34'd4);
        chk(l2_log[0] == VEC[2][33:0], "R4 wrap order0", l2_log[0], VEC[2][33:0]);
        chk(l2_log[3] == gen_item(1), "R4 wrap order3", l2_log[3], gen_item(1));

        // R8: erase at head (eldest discarded)
        @(negedge clk); erase_ptr = 4'd6; erase_req = 1'b1;
        run_op(-1);
        chk(tail_ptr == 6 && head_ptr == 6, "R8 emptied", 34'({tail_ptr, head_ptr}), 34'h66);
        chk(l1_n == 0, "R8 no replay", 34'(l1_n), 34'd0);

        // R10: simultaneous commands, erase wins
        append({16'h0500, 16'h6601, 2'd1});
        append({16'h0600, 16'h6602, 2'd3});
        @(negedge clk);
        erase_ptr = 4'd8; inval_line = 12'h070; drain_ptr = 4'd7;
        erase_req = 1'b1; inval_req = 1'b1; drain_req = 1'b1;
        run_op(-1);
        chk(l2_n == 0 && head_ptr == 6, "R10 no drain", 34'({l2_n[3:0], head_ptr}), 34'h06);
        chk(tail_ptr == 8, "R10 tail", 34'(tail_ptr), 34'd8);
        chk(l1_n == 2, "R10 full replay count", 34'(l1_n), 34'd2);
        chk(l1_log[1] == {16'h0600, 16'h6602, 2'd3}, "R10 replay item1", l1_log[1], {16'h0600, 16'h6602, 2'd3});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule